// File: doc/BRIEF.md
# Synchronous Serial Transmit Channel

This block is the sending side of a synchronous serial port. A host places words into a 16-bit holding register. The block copies each word into an output shift register on its own, then sends it most significant bit first on a serial data line, one bit per transmit clock. A frame-sync pulse marks the start of every word. The block can generate that pulse itself at a programmed period, or take it from an external pin. The holding register and the shift register together form a two-deep buffer. A one-cycle ready interrupt tells the host when the holding register has room again. Two sticky status flags report a missed frame (underflow) and a rejected write (overflow).

The transmit clock arrives on a pin and is resynchronised to the system clock. Every action happens on the system clock edge that follows the transmit clock edge the block detects. A polarity input selects the transmit clock edge that drives data and the internal frame sync. The opposite edge samples the external frame sync.

Top module: `sertx_chan`

## Requirements
- R1: After reset, and on the system clock after any cycle in which `en_i` is low, `sdo_o` and `fs_o` are 0. Reset also clears `irq_o`, `uf_o` and `ovf_o`.
- R2: The holding register and the shift register hold at most two words together. A word stays in the shift register until its last bit has been driven, and only then is the held word transferred.
- R3: A write while the holding register is full is dropped, so the dropped word is never sent. It sets `ovf_o`, which stays set while enabled and clears on the first clock with `en_i` low.
- R4: When the shift register is empty, the port is enabled and the holding register has a word, the word moves to the shifter without host action. `irq_o` pulses high for exactly one system clock, one clock after that transfer.
- R5: While `dma_en_i` is high, a transfer produces no `irq_o` pulse.
- R6: `wlen_i` = w selects a word of w+1 bits, for w from 2 to 15. Bits w down to 0 of the word are sent, most significant first, and higher bits are never sent. `wlen_i` is captured when `en_i` rises.
- R7: With `fs_int_i` = 1, `fs_o` is high for exactly one transmit clock. It goes high on the first drive edge after enable and then every `period_i` drive edges. The first data bit follows on the next drive edge.
- R8: With `fs_int_i` = 0, `fs_i` high at a sample edge marks a frame. The next drive edge starts the word, and the first data bit follows on the drive edge after that.
- R9: With `edge_sel_i` = 1, `sdo_o` and `fs_o` change only after falling edges of `sclk_i`, and `fs_i` is sampled on rising edges. With `edge_sel_i` = 0, the edges are swapped.
- R10: A frame that arrives while no word is sending and the shift register is empty sets `uf_o`.
- R11: `uf_o` stays set while the port is disabled. After `en_i` rises, it clears on the 4th drive edge and not before.
- R12: A frame sync that arrives while a word is being sent is ignored. The word is not restarted and `uf_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Port enable |
| edge_sel_i | input | 1 | 1: drive on falling and sample on rising sclk edges; 0: the reverse |
| fs_int_i | input | 1 | 1: internal frame sync; 0: external frame sync on fs_i |
| wlen_i | input | 4 | Word length minus one |
| period_i | input | 8 | Internal frame period in transmit clocks (at least 2) |
| dma_en_i | input | 1 | Masks the ready interrupt |
| wr_i | input | 1 | Holding-register write strobe |
| wdata_i | input | 16 | Write data, right-justified |
| sclk_i | input | 1 | Transmit clock |
| fs_i | input | 1 | External frame sync |
| sdo_o | output | 1 | Serial data out |
| fs_o | output | 1 | Internal frame sync out |
| irq_o | output | 1 | Ready interrupt pulse |
| uf_o | output | 1 | Sticky underflow flag |
| ovf_o | output | 1 | Sticky write-overflow flag |

## Verification
The embedded assertions check on every cycle that:
- the interrupt is a single-cycle pulse that is never raised while DMA is enabled;
- the overflow flag rises only after a write to a full register;
- the underflow flag falls only while the port is enabled;
- the outputs are idle after a disabled cycle.

Only the bench scenarios can show the rest:
- the exact bit order and word length;
- frame spacing and the edge on which each output moves;
- the four-edge delay before underflow clears;
- that a frame sync during a word is ignored.

To do this, the bench compares every output against its own queue-based model on every clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned UF_CLEAR_EDGES = 4;

  typedef enum logic {
    FS_EXT = 1'b0,
    FS_INT = 1'b1
  } fs_src_e;
endpackage

// File: rtl/sertx_edge.sv
module sertx_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic edge_sel_i,
  output logic drv_o,
  output logic smp_o
);
  localparam int unsigned N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [N-1:0] sync_q;
  logic         rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= sclk_i;
  end

  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign rise  = sync_q[N-2] & ~sync_q[N-1];
  assign fall  = ~sync_q[N-2] & sync_q[N-1];
  assign drv_o = edge_sel_i ? fall : rise;
  assign smp_o = edge_sel_i ? rise : fall;
endmodule

// File: rtl/sertx_buf.sv
module sertx_buf #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          dma_en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sh_free_i,
  output logic          xfer_o,
  output logic [DW-1:0] xfer_word_o,
  output logic          irq_o,
  output logic          ovf_o
);
  logic [DW-1:0] hold_q;
  logic          full_q;

  assign xfer_o      = en_i & full_q & sh_free_i;
  assign xfer_word_o = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
      irq_o  <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      irq_o <= xfer_o & ~dma_en_i;
      if (!en_i)               ovf_o <= 1'b0;
      else if (wr_i && full_q) ovf_o <= 1'b1;
      if (wr_i && !full_q) begin
        hold_q <= wdata_i;
        full_q <= 1'b1;
      end else if (xfer_o) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(wr_i && full_q)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !$past(dma_en_i)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R4
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          fs_int_i,
  input  logic [PW-1:0] period_i,
  input  logic          drv_i,
  input  logic          smp_i,
  input  logic          fs_i,
  output logic          frame_o,
  output logic          fs_o
);
  import sertx_pkg::*;

  fs_src_e       src;
  logic [PW-1:0] cnt_q;
  logic          pend_q;

  assign src     = fs_src_e'(fs_int_i);
  assign frame_o = (src == FS_INT) ? (cnt_q == '0) : pend_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      fs_o   <= 1'b0;
    end else if (drv_i) begin
      fs_o   <= (src == FS_INT) && (cnt_q == '0);
      cnt_q  <= (cnt_q == period_i - 1'b1) ? '0 : cnt_q + 1'b1;
      pend_q <= 1'b0;
    end else if (smp_i && fs_i) begin
      pend_q <= 1'b1;
    end
  end

  AST_FS_ONLY_INT: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_o) |-> $past(fs_int_i)); // R7
endmodule

// File: rtl/sertx_chan.sv
module sertx_chan #(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_i,
  input  logic                  edge_sel_i,
  input  logic                  fs_int_i,
  input  logic [$clog2(DW)-1:0] wlen_i,
  input  logic [PW-1:0]         period_i,
  input  logic                  dma_en_i,
  input  logic                  wr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  sclk_i,
  input  logic                  fs_i,
  output logic                  sdo_o,
  output logic                  fs_o,
  output logic                  irq_o,
  output logic                  uf_o,
  output logic                  ovf_o
);
  import sertx_pkg::*;

  localparam int unsigned LW = $clog2(DW);
  localparam int unsigned CW = (UF_CLEAR_EDGES > 2) ? $clog2(UF_CLEAR_EDGES) : 1;
  localparam logic [CW-1:0] CLR_LAST = CW'(UF_CLEAR_EDGES - 1);

  logic          drv, smp, frame, xfer;
  logic [DW-1:0] xfer_word;
  logic [DW-1:0] sh_q;
  logic          loaded_q, sending_q, en_q, arm_q;
  logic [LW-1:0] idx_q, wl_q;
  logic [CW-1:0] clr_q;
  logic          uf_set, uf_clr;

  sertx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .edge_sel_i(edge_sel_i),
    .drv_o(drv), .smp_o(smp));

  sertx_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .en_i(en_i), .dma_en_i(dma_en_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .sh_free_i(!loaded_q), .xfer_o(xfer),
    .xfer_word_o(xfer_word), .irq_o(irq_o), .ovf_o(ovf_o));

  sertx_frame #(.PW(PW)) u_frame (
    .clk(clk), .rst(rst), .en_i(en_i), .fs_int_i(fs_int_i),
    .period_i(period_i), .drv_i(drv), .smp_i(smp), .fs_i(fs_i),
    .frame_o(frame), .fs_o(fs_o));

  assign uf_set = en_i && drv && frame && !sending_q && !loaded_q;
  assign uf_clr = en_i && drv && arm_q && (clr_q == CLR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      wl_q      <= '1;
      sh_q      <= '0;
      loaded_q  <= 1'b0;
      sending_q <= 1'b0;
      idx_q     <= '0;
      sdo_o     <= 1'b0;
      arm_q     <= 1'b0;
      clr_q     <= '0;
    end else begin
      en_q <= en_i;
      if (en_i && !en_q) wl_q <= wlen_i;
      if (!en_i) begin
        loaded_q  <= 1'b0;
        sending_q <= 1'b0;
        sdo_o     <= 1'b0;
        arm_q     <= 1'b0;
        clr_q     <= '0;
      end else begin
        if (!en_q) begin
          arm_q <= 1'b1;
          clr_q <= '0;
        end
        if (xfer) begin
          sh_q     <= xfer_word;
          loaded_q <= 1'b1;
        end
        if (drv) begin
          if (sending_q) begin
            sdo_o <= sh_q[idx_q];
            if (idx_q == '0) begin
              sending_q <= 1'b0;
              loaded_q  <= 1'b0;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end else begin
            sdo_o <= 1'b0;
            if (frame && loaded_q) begin
              sending_q <= 1'b1;
              idx_q     <= wl_q;
            end
          end
          if (arm_q) begin
            if (clr_q == CLR_LAST) arm_q <= 1'b0;
            else                   clr_q <= clr_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         uf_o <= 1'b0;
    else if (uf_set) uf_o <= 1'b1;
    else if (uf_clr) uf_o <= 1'b0;
  end

  AST_UF_FALL_ENABLED: assert property (@(posedge clk) disable iff (rst)
    ($fell(uf_o) && !$past(rst)) |-> $past(en_i)); // R11
  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!$past(en_i) && !$past(rst)) |-> (!sdo_o && !fs_o)); // R1
  AST_SEND_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    sending_q |-> loaded_q); // R2
endmodule

// File: tb/sertx_chan_tb.sv
module sertx_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, edge_sel = 1'b0, fs_int = 1'b1, dma_en = 1'b0;
  logic [3:0]  wlen = 4'd7;
  logic [7:0]  period = 8'd12;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        sclk = 1'b0, fs_in = 1'b0;
  logic        sdo, fs_out, irq, uf, ovf;

  int errors = 0, checks = 0;
  string cur = "R1";
  int irq_cnt = 0;
  int ph = 0;
  logic prev_sdo = 1'b0;

  always #10 clk = ~clk;

  sertx_chan u_dut (
    .clk(clk), .rst(rst), .en_i(en), .edge_sel_i(edge_sel), .fs_int_i(fs_int),
    .wlen_i(wlen), .period_i(period), .dma_en_i(dma_en), .wr_i(wr),
    .wdata_i(wdata), .sclk_i(sclk), .fs_i(fs_in), .sdo_o(sdo), .fs_o(fs_out),
    .irq_o(irq), .uf_o(uf), .ovf_o(ovf));

  // transmit clock: toggles every 3 system clocks
  always @(negedge clk) begin
    if (ph == 2) begin sclk <= ~sclk; ph <= 0; end
    else ph <= ph + 1;
  end

  // behavioural reference model
  logic [15:0] mq[$];
  logic mld, msnd, ms1, ms2, men_q, mpend, mfs, msdo, mirq, muf, movf, marm;
  int   midx, mwl, mfc, mcnt;
  logic rise, fall, drv, smp, hf, dox, fr, pld, psnd, parm, setuf;
  int   pcnt;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mld = 0; msnd = 0; ms1 = 0; ms2 = 0; men_q = 0; mpend = 0;
      mfs = 0; msdo = 0; mirq = 0; muf = 0; movf = 0; marm = 0;
      midx = 0; mwl = 15; mfc = 0; mcnt = 0;
    end else begin
      rise = ms1 && !ms2; fall = !ms1 && ms2;
      drv = edge_sel ? fall : rise;
      smp = edge_sel ? rise : fall;
      hf = (mq.size() > (mld ? 1 : 0));
      dox = en && hf && !mld;
      fr = fs_int ? (mfc == 0) : mpend;
      pld = mld; psnd = msnd; parm = marm; pcnt = mcnt; setuf = 0;
      mirq = dox && !dma_en;
      if (!en) movf = 0; else if (wr && hf) movf = 1;
      if (!en) begin
        if (mld) void'(mq.pop_front());
        mld = 0; msnd = 0; msdo = 0; mfs = 0; mfc = 0; mpend = 0; marm = 0; mcnt = 0;
      end else begin
        if (!men_q) begin marm = 1; mcnt = 0; end
        if (drv) begin
          if (psnd) begin
            msdo = mq[0][midx];
            if (midx == 0) begin msnd = 0; mld = 0; void'(mq.pop_front()); end
            else midx = midx - 1;
          end else begin
            msdo = 0;
            if (fr) begin
              if (pld) begin msnd = 1; midx = mwl; end
              else begin muf = 1; setuf = 1; end
            end
          end
          mfs = fs_int && (mfc == 0);
          mfc = (mfc == int'(period) - 1) ? 0 : mfc + 1;
          mpend = 0;
          if (parm) begin
            if (pcnt == 3) begin marm = 0; if (!setuf) muf = 0; end
            else mcnt = pcnt + 1;
          end
        end else if (smp && fs_in) mpend = 1;
        if (dox) mld = 1;
      end
      if (en && !men_q) mwl = int'(wlen);
      if (wr && !hf) mq.push_back(wdata);
      men_q = en; ms2 = ms1; ms1 = sclk;
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // every-clock comparison, interrupt counting and edge monitor
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur, "sdo", sdo, msdo);
      chk(cur, "fs_o", fs_out, mfs);
      chk(cur, "irq", irq, mirq);
      chk(cur, "uf", uf, muf);
      chk(cur, "ovf", ovf, movf);
      if (irq) irq_cnt++;
      if (sdo !== prev_sdo) chk("R9", "sclk level at sdo change", sclk, !edge_sel);
      prev_sdo = sdo;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk); wr = 1'b1; wdata = w;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic fs_pulse();
    @(negedge clk); fs_in = 1'b1;
    cyc(6); fs_in = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    cyc(200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(5);
    checks += 5;
    if (sdo !== 0 || fs_out !== 0 || irq !== 0 || uf !== 0 || ovf !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs act=%b%b%b%b%b exp=00000", sdo, fs_out, irq, uf, ovf);
    end
    @(negedge clk); rst = 1'b0;

    // internal frames, rising-edge drive, 8-bit words, overflow
    cur = "R7";
    put(16'h00A5);
    irq_cnt = 0;
    @(negedge clk); en = 1'b1;
    cyc(2);
    cur = "R2";
    put(16'h003C);
    put(16'h0077);
    cyc(1);
    chk("R3", "ovf after write to full", ovf, 1'b1);
    cyc(200);
    chk("R10", "uf after empty frame", uf, 1'b1);
    checks++;
    if (irq_cnt != 2) begin
      errors++; $display("FAIL R4 irq pulses act=%0d exp=2", irq_cnt);
    end

    // disable keeps underflow, clears overflow; falling-edge drive, 12-bit
    @(negedge clk); en = 1'b0;
    cyc(3);
    chk("R3", "ovf after disable", ovf, 1'b0);
    chk("R11", "uf while disabled", uf, 1'b1);
    cur = "R9";
    edge_sel = 1'b1; wlen = 4'd11; period = 8'd16;
    put(16'h0ABC);
    @(negedge clk); en = 1'b1;
    cyc(2);
    chk("R11", "uf soon after enable", uf, 1'b1);
    put(16'h0123);
    cyc(120);
    chk("R11", "uf after four drive edges", uf, 1'b0);

    // external frames, 3-bit words, DMA masking, frame during a word
    @(negedge clk); en = 1'b0;
    cyc(3);
    cur = "R8";
    dma_en = 1'b1; fs_int = 1'b0; edge_sel = 1'b0; wlen = 4'd2;
    irq_cnt = 0;
    put(16'hFFF5);
    @(negedge clk); en = 1'b1;
    put(16'h8006);
    cyc(20);
    fs_pulse();
    cyc(6);
    cur = "R12";
    fs_pulse();
    cyc(40);
    cur = "R8";
    fs_pulse();
    cyc(60);
    checks++;
    if (irq_cnt != 0) begin
      errors++; $display("FAIL R5 irq pulses with dma act=%0d exp=0", irq_cnt);
    end

    // full 16-bit word, external frame, falling-edge drive
    @(negedge clk); en = 1'b0;
    cyc(3);
    cur = "R6";
    dma_en = 1'b0; edge_sel = 1'b1; wlen = 4'd15;
    put(16'h9C3E);
    @(negedge clk); en = 1'b1;
    cyc(12);
    fs_pulse();
    cyc(140);
    summary();
  end
endmodule